// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Lookup

This block answers instruction fetches from a processor core out of a read-only, direct-mapped store of 512 lines of 16 bytes. Each fetch reads the tag store and the data store together and, in the same cycle, returns the addressed 32-bit word when the line is present and valid. A fetch that misses raises a single request pulse toward a fill unit. The pulse carries the line-aligned address. The fill unit later writes a whole line back through the install port.

The install port also serves as a one-line fill buffer. A fetch that falls in the line being installed in that cycle is answered from the install data rather than from the arrays. A tightly coupled SRAM sits beside the cache and takes priority. When the core signals that the fetch address belongs to that SRAM, the cache reports no hit, drives zero data and starts no line request. A synchronous invalidate input, also applied by reset, drops every line at once.

Top module: `icache_lookup`

## Requirements
- R1: While reset is low and after it is released, every line reads as invalid, so a fetch to any address gives `hit_o` low and `line_req_o` stays low until a miss has been seen.
- R2: After a line has been installed, a fetch to any of its words gives `hit_o` high and that word on `rdata_o` in the same cycle. The word is chosen by fetch address bits [3:2].
- R3: A fetch whose address bits [31:12] differ from the stored tag at the same index (bits [12:4]) is a miss.
- R4: A miss with no request outstanding sets `line_req_o` high in the next cycle. At that point `line_addr_o` holds the fetch address with bits [3:0] cleared.
- R5: Only one request is outstanding at a time. It stays outstanding from its pulse until the next install. While it is outstanding, further misses raise no pulse, and `line_req_o` never stays high for two cycles in a row.
- R6: An install with `fill_valid_i` high writes all four words of the line at index `fill_addr_i[12:4]` and makes that line valid from the next cycle. Word k is taken from `fill_data_i[32k+31:32k]` and serves byte offset 4k. The install also ends any outstanding request.
- R7: A fetch that matches `fill_addr_i[31:4]` while `fill_valid_i` is high hits in that cycle and returns the corresponding word of `fill_data_i`.
- R8: While `sram_hit_i` is high, `hit_o` is low and that fetch raises no request in the next cycle.
- R9: `inv_i` makes every line invalid from the next cycle. It wins over an install in the same cycle.
- R10: `rdata_o` is zero whenever `hit_o` is low.
- R11: With `fetch_valid_i` low, `hit_o` is low and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inv_i | input | 1 | Invalidate all lines |
| fetch_valid_i | input | 1 | Fetch request present |
| fetch_addr_i | input | 32 | Fetch byte address |
| sram_hit_i | input | 1 | Fetch address belongs to the local SRAM |
| hit_o | output | 1 | Fetch served by the cache this cycle |
| rdata_o | output | 32 | Fetched word, zero when not a hit |
| line_req_o | output | 1 | One-cycle line request pulse |
| line_addr_o | output | 32 | Line-aligned address of the last request |
| fill_valid_i | input | 1 | Install a whole line this cycle |
| fill_addr_i | input | 32 | Address of the line being installed |
| fill_data_i | input | 128 | Line contents, word k in bits [32k+31:32k] |

## Verification
Hit, data and SRAM suppression are combinational results, so they are due in the cycle of the fetch. A line request is due one cycle after the miss that causes it. An install or invalidate takes effect on the fetch of the following cycle. The bench drives each cycle's inputs on the falling edge and computes the expected hit, data and request for that same cycle from its own line model. It then queues them, and a monitor compares them just before the next rising edge. The request expected in a cycle is therefore the one the model issued for the previous cycle's miss.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_WAIT = 1'b1
  } req_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int LINES = 512,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // invalidate beats a same-cycle install
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (inv_i)   valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

  p_inv_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (valid_q == '0));

  p_install_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inv_i) |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int LINES  = 512,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WOFF_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WOFF_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [DATA_W-1:0] mem_q [LINES*WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < WORDS; k++) begin
        mem_q[{wr_idx_i, WOFF_W'(k)}] <= wr_line_i[k*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem_q[{rd_idx_i, rd_word_i}];
endmodule

// File: rtl/icache_miss_ctrl.sv
module icache_miss_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              fill_done_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  req_state_e state_q, state_d;
  logic issue;

  assign issue = miss_i && (state_q == REQ_IDLE);

  always_comb begin
    state_d = state_q;
    if (issue)            state_d = REQ_WAIT;
    else if (fill_done_i) state_d = REQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= REQ_IDLE;
      req_o      <= 1'b0;
      req_addr_o <= '0;
    end else begin
      state_q <= state_d;
      req_o   <= issue;
      if (issue) req_addr_o <= {miss_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_req_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_addr_o[OFF_W-1:0] == '0));

  p_req_after_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(miss_i));
endmodule

// File: rtl/icache_lookup.sv
module icache_lookup #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 512,
  localparam int WORDS   = LINE_BYTES / (DATA_W / 8),
  localparam int BOFF_W  = $clog2(DATA_W / 8),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int WOFF_W  = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_LSB = OFF_W + IDX_W - 1,
  localparam int TAG_W   = ADDR_W - TAG_LSB,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              sram_hit_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              line_req_o,
  output logic [ADDR_W-1:0] line_addr_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [LINE_W-1:0] fill_data_i
);
  // tag keeps the top index bit as well; it is redundant but harmless
  logic [IDX_W-1:0]  f_idx, w_idx;
  logic [WOFF_W-1:0] f_word;
  logic [TAG_W-1:0]  f_tag, w_tag;
  logic              arr_hit, byp_hit, active, miss;
  logic [DATA_W-1:0] arr_word, byp_word;
  logic              unused_bits;

  assign f_idx  = fetch_addr_i[OFF_W +: IDX_W];
  assign f_word = fetch_addr_i[BOFF_W +: WOFF_W];
  assign f_tag  = fetch_addr_i[ADDR_W-1:TAG_LSB];
  assign w_idx  = fill_addr_i[OFF_W +: IDX_W];
  assign w_tag  = fill_addr_i[ADDR_W-1:TAG_LSB];
  assign unused_bits = ^{fetch_addr_i[BOFF_W-1:0], fill_addr_i[OFF_W-1:0]};

  icache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inv_i    (inv_i),
    .rd_idx_i (f_idx),
    .rd_tag_i (f_tag),
    .rd_hit_o (arr_hit),
    .wr_en_i  (fill_valid_i),
    .wr_idx_i (w_idx),
    .wr_tag_i (w_tag)
  );

  icache_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (f_idx),
    .rd_word_i (f_word),
    .rd_data_o (arr_word),
    .wr_en_i   (fill_valid_i),
    .wr_idx_i  (w_idx),
    .wr_line_i (fill_data_i)
  );

  // fill buffer check runs beside the tag check
  assign byp_hit  = fill_valid_i &&
                    (fill_addr_i[ADDR_W-1:OFF_W] == fetch_addr_i[ADDR_W-1:OFF_W]);
  assign byp_word = fill_data_i[f_word*DATA_W +: DATA_W];

  assign active  = fetch_valid_i && !sram_hit_i;
  assign hit_o   = active && (byp_hit || arr_hit);
  assign miss    = active && !byp_hit && !arr_hit;
  assign rdata_o = !hit_o ? '0 : (byp_hit ? byp_word : arr_word);

  icache_miss_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_miss (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (miss),
    .miss_addr_i (fetch_addr_i),
    .fill_done_i (fill_valid_i),
    .req_o       (line_req_o),
    .req_addr_o  (line_addr_o)
  );

  p_sram_nohit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_hit_i |-> !hit_o);

  p_sram_noreq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_hit_i |=> !line_req_o);

  p_idle_noreq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !line_req_o);

  p_rdata_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (rdata_o == '0));
endmodule

// File: tb/tb_icache_lookup.sv
module tb_icache_lookup;
  localparam int CYC = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         inv_i = 1'b0;
  logic         fetch_valid_i = 1'b0;
  logic [31:0]  fetch_addr_i = '0;
  logic         sram_hit_i = 1'b0;
  logic         hit_o;
  logic [31:0]  rdata_o;
  logic         line_req_o;
  logic [31:0]  line_addr_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [127:0] fill_data_i = '0;

  always #(CYC/2) clk_i = ~clk_i;

  icache_lookup dut (
    .clk_i, .rst_ni, .inv_i, .fetch_valid_i, .fetch_addr_i, .sram_hit_i,
    .hit_o, .rdata_o, .line_req_o, .line_addr_o,
    .fill_valid_i, .fill_addr_i, .fill_data_i
  );

  typedef struct {
    string       tag;
    bit          hit;
    logic [31:0] rdata;
    bit          req;
    logic [31:0] laddr;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  // requirement model
  bit          m_v [512];
  logic [19:0] m_tag [512];
  logic [31:0] m_dat [512][4];
  bit          m_pend = 0;
  bit          m_req = 0;
  logic [31:0] m_laddr = '0;

  task automatic step(input bit fv, input logic [31:0] a, input bit sr,
                      input bit flv, input logic [31:0] fa, input logic [127:0] fd,
                      input bit iv, input string tg);
    exp_t e;
    int idx, w, fidx;
    bit byp, ahit, hit, miss, issue;
    @(negedge clk_i);
    fetch_valid_i = fv; fetch_addr_i = a; sram_hit_i = sr;
    fill_valid_i = flv; fill_addr_i = fa; fill_data_i = fd; inv_i = iv;
    idx = int'(a[12:4]); w = int'(a[3:2]); fidx = int'(fa[12:4]);
    byp  = flv && (fa[31:4] == a[31:4]);
    ahit = m_v[idx] && (m_tag[idx] == a[31:12]);
    hit  = fv && !sr && (byp || ahit);
    miss = fv && !sr && !hit;
    e.tag = tg; e.hit = hit;
    e.rdata = !hit ? 32'h0 : (byp ? fd[w*32 +: 32] : m_dat[idx][w]);
    e.req = m_req; e.laddr = m_laddr;
    q.push_back(e);
    issue = miss && !m_pend;
    m_req = issue;
    if (issue) m_laddr = {a[31:4], 4'h0};
    m_pend = (m_pend && !flv) || issue;
    if (iv) begin
      for (int i = 0; i < 512; i++) m_v[i] = 0;
    end else if (flv) begin
      m_v[fidx] = 1; m_tag[fidx] = fa[31:12];
      for (int k = 0; k < 4; k++) m_dat[fidx][k] = fd[k*32 +: 32];
    end
  endtask

  task automatic check(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #(CYC/2 - 1);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "hit_o", 32'(hit_o), 32'(e.hit));
        check(e.tag, "rdata_o", rdata_o, e.rdata);
        check(e.tag, "line_req_o", 32'(line_req_o), 32'(e.req));
        if (e.req) check(e.tag, "line_addr_o", line_addr_o, e.laddr);
      end
    end
  end

  initial begin
    #(CYC * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] A = 32'h1234_5058;
  localparam logic [31:0] B = A + 32'h0000_2000; // same index, other tag
  localparam logic [31:0] C = 32'h0000_0104;
  localparam logic [127:0] LA = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
  localparam logic [127:0] LB = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};
  localparam logic [127:0] LC = {32'hC3C3_0003, 32'hC2C2_0002, 32'hC1C1_0001, 32'hC0C0_0000};

  initial begin
    for (int i = 0; i < 512; i++) m_v[i] = 0;
    repeat (3) @(negedge clk_i);
    check("R1", "hit_o in reset", 32'(hit_o), 32'h0);
    check("R1", "line_req_o in reset", 32'(line_req_o), 32'h0);
    rst_ni = 1'b1;
    step(0, A, 0, 0, 0, 0, 0, "R11");
    step(1, A, 0, 0, 0, 0, 0, "R1");
    step(1, A, 0, 0, 0, 0, 0, "R4");
    step(1, A, 0, 0, 0, 0, 0, "R5");
    step(1, A, 0, 0, 0, 0, 0, "R5");
    step(1, A + 4, 0, 1, A, LA, 0, "R7");
    step(1, A & ~32'hF, 0, 0, 0, 0, 0, "R6");
    step(1, A, 0, 0, 0, 0, 0, "R2");
    step(1, (A & ~32'hF) + 8, 0, 0, 0, 0, 0, "R6");
    step(1, (A & ~32'hF) + 12, 0, 0, 0, 0, 0, "R6");
    step(1, B, 0, 0, 0, 0, 0, "R3");
    step(1, B, 0, 0, 0, 0, 0, "R4");
    step(1, A, 1, 0, 0, 0, 0, "R8");
    step(1, A + 4, 1, 0, 0, 0, 0, "R10");
    step(0, A, 0, 0, 0, 0, 0, "R11");
    step(1, B, 0, 1, B, LB, 0, "R7");
    step(1, A, 0, 0, 0, 0, 0, "R3");
    step(1, C, 1, 0, 0, 0, 0, "R4");
    step(1, C, 1, 1, C, LC, 0, "R8");
    step(0, C, 0, 0, 0, 0, 0, "R8");
    step(1, C + 8, 0, 0, 0, 0, 0, "R2");
    step(1, B + 4, 0, 0, 0, 0, 0, "R2");
    step(1, C, 0, 1, A, LA, 1, "R9");
    step(1, A, 0, 0, 0, 0, 0, "R9");
    step(1, C, 0, 0, 0, 0, 0, "R9");
    step(1, B, 0, 0, 0, 0, 0, "R5");
    step(0, B, 0, 1, C, LC, 0, "R6");
    step(1, C + 12, 0, 0, 0, 0, 0, "R6");
    step(1, A, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule